// File: doc/BRIEF.md
# Two-Rank Crosspoint Routing Controller

This block holds the routing map of a 32-output by 32-input crosspoint. Every output either selects one input or is switched off, and any input may feed many outputs at once. New routing is staged in a preload rank that does not disturb live traffic. A single update strobe then copies the whole staged map into the active rank, so that every output switches in the same clock cycle.

The preload rank is written in one of two ways, chosen by a mode input. In serial mode the rank is one long shift chain with a serial output at its far end, so that several devices can share one data line. In parallel mode an addressed write port loads one output's entry, or all of them at once with a broadcast flag. The active rank drives per-output select and enable pins and a byte-lane data crosspoint.

The data lanes are a plain valid-qualified stream with no ready. Each output lane copies the valid and data of its selected input in the same cycle and applies no back-pressure, so a sink must take every beat it is offered. Reset clears only the active rank.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: For an enabled output, `out_data` lane o equals input lane `sel` of `in_data` and `out_valid[o]` equals `in_valid[sel]` in the same cycle.
- R2: Several outputs may select the same input, and each of them carries that input's data and valid.
- R3: Serial shifts and parallel writes change no `out_en`/`out_sel` value; the active rank changes only on `upd` or reset.
- R4: With `upd` high at a clock edge, all 32 active entries take the preload values, visible after that edge.
- R5: `load_par`=0 selects serial loading: the chain shifts only when `shift_en` is high and parallel writes are ignored. `load_par`=1 selects parallel loading: `shift_en` is ignored.
- R6: Each entry is 6 bits, bit 5 the enable and bits 4:0 the input index. Output k occupies chain bits [6k+5:6k] of a 192-bit chain. A shift moves the chain up one bit and takes `ser_in` into bit 0, so after 192 shifts the first bit sent is output 31's enable.
- R7: `ser_out` always shows chain bit 191, the bit that the next shift pushes out.
- R8: Reset sets every `out_en` to 0 and leaves the preload rank unchanged, so an `upd` after reset restores the staged map.
- R9: A parallel write with `wr_all` high loads `wr_entry` into all 32 preload entries.
- R10: A parallel write and `upd` in the same cycle send the old preload value to the active rank; the new value takes effect on a later `upd`.
- R11: A disabled output drives zero on its data lane and holds `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the active rank |
| load_par | input | 1 | Load mode: 0 serial, 1 parallel |
| shift_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out, end of chain |
| wr_en | input | 1 | Parallel write strobe |
| wr_all | input | 1 | Broadcast write to every entry |
| wr_addr | input | 5 | Output addressed by a parallel write |
| wr_entry | input | 6 | Entry for a parallel write: enable and index |
| upd | input | 1 | Global copy of the preload rank to the active rank |
| in_data | input | 256 | 32 input byte lanes |
| in_valid | input | 32 | Per-input valid |
| out_data | output | 256 | 32 output byte lanes |
| out_valid | output | 32 | Per-output valid |
| out_sel | output | 160 | Active input index per output, 5 bits each |
| out_en | output | 32 | Active enable per output |

## Verification
The routing is loaded as a full random map through the parallel port and as a random 192-bit stream through the serial chain. The map is also loaded as a broadcast with every output on one input, which separates true multicast from a one-to-one permutation. Each map is checked under several random data and valid patterns, so that a wrong select shows up as a data mismatch and a disabled lane shows up if it leaks. Directed cases cover the following:
- a write in the same cycle as the update, which tells old-value from new-value capture;
- strobes given in the wrong mode;
- a reset between staging and update, which shows whether the preload rank survives;
- a second full shift, which checks `ser_out` against the bits loaded earlier.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  typedef enum logic {
    LOAD_SERIAL   = 1'b0,
    LOAD_PARALLEL = 1'b1
  } load_mode_e;
endpackage

// File: rtl/xpt_preload.sv
module xpt_preload
  import xpt_cfg_pkg::*;
#(
  parameter int N_OUT = 32,
  parameter int ENT_W = 6,
  parameter int AW    = 5
) (
  input  logic                   clk,
  input  logic                   load_par,
  input  logic                   shift_en,
  input  logic                   ser_in,
  input  logic                   wr_en,
  input  logic                   wr_all,
  input  logic [AW-1:0]          wr_addr,
  input  logic [ENT_W-1:0]       wr_entry,
  output logic [N_OUT*ENT_W-1:0] pre,
  output logic                   ser_out
);
  localparam int CH = N_OUT * ENT_W;

  load_mode_e mode;
  assign mode = load_mode_e'(load_par);

  // Preload rank is deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (mode == LOAD_SERIAL) begin
      if (shift_en) pre <= {pre[CH-2:0], ser_in};
    end else if (wr_en) begin
      for (int k = 0; k < N_OUT; k++) begin
        if (wr_all || wr_addr == AW'(k)) pre[k*ENT_W +: ENT_W] <= wr_entry;
      end
    end
  end

  assign ser_out = pre[CH-1];
endmodule

// File: rtl/xpt_active.sv
module xpt_active #(
  parameter int N_OUT = 32,
  parameter int ENT_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd,
  input  logic [N_OUT*ENT_W-1:0] pre,
  output logic [N_OUT*ENT_W-1:0] act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   act <= '0;
    else if (upd) act <= pre;
  end
endmodule

// File: rtl/xpt_fabric.sv
module xpt_fabric #(
  parameter int N_OUT  = 32,
  parameter int N_IN   = 32,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 5,
  parameter int ENT_W  = 6
) (
  input  logic [N_OUT*ENT_W-1:0]  act,
  input  logic [N_IN*LANE_W-1:0]  in_data,
  input  logic [N_IN-1:0]         in_valid,
  output logic [N_OUT*LANE_W-1:0] out_data,
  output logic [N_OUT-1:0]        out_valid,
  output logic [N_OUT*IDX_W-1:0]  out_sel,
  output logic [N_OUT-1:0]        out_en
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic             en;
    logic [IDX_W-1:0] sel;
    logic [LANE_W-1:0] d;
    logic             v;

    assign en = act[o*ENT_W + ENT_W - 1];
    assign sel = act[o*ENT_W +: IDX_W];

    always_comb begin
      d = '0;
      v = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (en && sel == IDX_W'(i)) begin
          d = in_data[i*LANE_W +: LANE_W];
          v = in_valid[i];
        end
      end
    end

    assign out_data[o*LANE_W +: LANE_W] = d;
    assign out_valid[o] = v;
    assign out_sel[o*IDX_W +: IDX_W] = sel;
    assign out_en[o] = en;
  end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl #(
  parameter int N_OUT  = 32,
  parameter int N_IN   = 32,
  parameter int LANE_W = 8,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int ENT_W = IDX_W + 1,
  localparam int AW    = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_par,
  input  logic                    shift_en,
  input  logic                    ser_in,
  output logic                    ser_out,
  input  logic                    wr_en,
  input  logic                    wr_all,
  input  logic [AW-1:0]           wr_addr,
  input  logic [ENT_W-1:0]        wr_entry,
  input  logic                    upd,
  input  logic [N_IN*LANE_W-1:0]  in_data,
  input  logic [N_IN-1:0]         in_valid,
  output logic [N_OUT*LANE_W-1:0] out_data,
  output logic [N_OUT-1:0]        out_valid,
  output logic [N_OUT*IDX_W-1:0]  out_sel,
  output logic [N_OUT-1:0]        out_en
);
  logic [N_OUT*ENT_W-1:0] pre;
  logic [N_OUT*ENT_W-1:0] act;

  xpt_preload #(.N_OUT(N_OUT), .ENT_W(ENT_W), .AW(AW)) u_pre (
    .clk(clk), .load_par(load_par), .shift_en(shift_en), .ser_in(ser_in),
    .wr_en(wr_en), .wr_all(wr_all), .wr_addr(wr_addr), .wr_entry(wr_entry),
    .pre(pre), .ser_out(ser_out)
  );

  xpt_active #(.N_OUT(N_OUT), .ENT_W(ENT_W)) u_act (
    .clk(clk), .rst_n(rst_n), .upd(upd), .pre(pre), .act(act)
  );

  xpt_fabric #(.N_OUT(N_OUT), .N_IN(N_IN), .LANE_W(LANE_W),
               .IDX_W(IDX_W), .ENT_W(ENT_W)) u_fab (
    .act(act), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid),
    .out_sel(out_sel), .out_en(out_en)
  );
endmodule

// File: rtl/xpt_cfg_ctrl_chk.sv
module xpt_cfg_ctrl_chk #(
  parameter int N_OUT  = 32,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    load_par,
  input logic                    shift_en,
  input logic                    wr_en,
  input logic                    upd,
  input logic                    ser_out,
  input logic [N_OUT*LANE_W-1:0] out_data,
  input logic [N_OUT-1:0]        out_valid,
  input logic [N_OUT*IDX_W-1:0]  out_sel,
  input logic [N_OUT-1:0]        out_en
);
  // R3: without an update the active routing holds
  assert_hold_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(out_en) && $stable(out_sel)));

  // R8: first cycle out of reset has every output disabled
  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_en == '0));

  // R7: the chain end moves only when a shift or a parallel write happens
  assert_ser_out_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((load_par && !wr_en) || (!load_par && !shift_en)) |=> $stable(ser_out));

  for (genvar o = 0; o < N_OUT; o++) begin : g_lane
    // R11: disabled lane is silent
    assert_off_lane_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[o] |-> (out_data[o*LANE_W +: LANE_W] == '0 && !out_valid[o]));
    // R1: valid only appears on an enabled output
    assert_valid_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] |-> out_en[o]);
  end
endmodule

bind xpt_cfg_ctrl xpt_cfg_ctrl_chk #(.N_OUT(N_OUT), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_par(load_par), .shift_en(shift_en),
  .wr_en(wr_en), .upd(upd), .ser_out(ser_out), .out_data(out_data),
  .out_valid(out_valid), .out_sel(out_sel), .out_en(out_en)
);

// File: tb/xpt_cfg_ctrl_test.sv
module xpt_cfg_ctrl_test;
  localparam int PERIOD = 10;
  localparam int NO = 32, NI = 32, LW = 8, IW = 5, EW = 6, CH = NO * EW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_par = 1'b1, shift_en = 1'b0, ser_in = 1'b0, ser_out;
  logic wr_en = 1'b0, wr_all = 1'b0, upd = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [EW-1:0] wr_entry = '0;
  logic [NI*LW-1:0] in_data = '0;
  logic [NI-1:0] in_valid = '0;
  logic [NO*LW-1:0] out_data;
  logic [NO-1:0] out_valid, out_en;
  logic [NO*IW-1:0] out_sel;

  logic [CH-1:0] m_pre = '0, m_act = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  xpt_cfg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .load_par(load_par), .shift_en(shift_en),
    .ser_in(ser_in), .ser_out(ser_out), .wr_en(wr_en), .wr_all(wr_all),
    .wr_addr(wr_addr), .wr_entry(wr_entry), .upd(upd), .in_data(in_data),
    .in_valid(in_valid), .out_data(out_data), .out_valid(out_valid),
    .out_sel(out_sel), .out_en(out_en)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    for (int o = 0; o < NO; o++) begin
      logic en; logic [IW-1:0] s; logic [LW-1:0] d; logic v;
      en = m_act[o*EW+5]; s = m_act[o*EW +: IW];
      d = en ? in_data[s*LW +: LW] : '0;
      v = en ? in_valid[s] : 1'b0;
      check($sformatf("%s out%0d en", tag, o), 256'(out_en[o]), 256'(en));
      check($sformatf("%s out%0d sel", tag, o), 256'(out_sel[o*IW +: IW]), 256'(s));
      check($sformatf("%s out%0d data/valid R1 R11", tag, o),
            256'({out_valid[o], out_data[o*LW +: LW]}), 256'({v, d}));
    end
  endtask

  task automatic rand_inputs();
    for (int i = 0; i < NI; i++) in_data[i*LW +: LW] = LW'($urandom);
    in_valid = $urandom;
  endtask

  task automatic pwrite(int a, logic [EW-1:0] e, bit all, bit with_upd);
    load_par = 1; wr_en = 1; wr_addr = 5'(a); wr_entry = e; wr_all = all; upd = with_upd;
    tick();
    wr_en = 0; wr_all = 0; upd = 0;
    if (with_upd) m_act = m_pre;
    for (int k = 0; k < NO; k++) if (all || k == a) m_pre[k*EW +: EW] = e;
  endtask

  task automatic do_upd();
    upd = 1; tick(); upd = 0; m_act = m_pre;
  endtask

  task automatic shift(bit b);
    check("R7 ser_out", 256'(ser_out), 256'(m_pre[CH-1]));
    load_par = 0; shift_en = 1; ser_in = b; tick(); shift_en = 0;
    m_pre = {m_pre[CH-2:0], b};
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [CH-1:0] img;
    void'($urandom(32'd20240611));
    tick(); tick();
    check("R8 reset out_en", 256'(out_en), 256'(0));
    check("R11 reset out_valid", 256'(out_valid), 256'(0));
    rst_n = 1; tick();

    // R3: parallel preload, active untouched; R4 update
    for (int k = 0; k < NO; k++) pwrite(k, EW'($urandom), 0, 0);
    rand_inputs(); #1;
    check("R3 active after writes", 256'(out_en), 256'(0));
    do_upd();
    for (int r = 0; r < 3; r++) begin rand_inputs(); #1; check_outs("R4 parallel map"); end

    // R9/R2: broadcast multicast to input 7
    pwrite(0, {1'b1, 5'd7}, 1, 0);
    do_upd(); rand_inputs(); #1;
    check_outs("R9 R2 broadcast");

    // R10: write with update in same cycle
    pwrite(3, {1'b1, 5'd21}, 0, 1);
    #1; check_outs("R10 same-cycle old value");
    do_upd(); #1; check_outs("R10 new value later");

    // R6/R7: serial random chain
    for (int k = 0; k < CH; k++) img[k] = 1'($urandom);
    img[CH-1 -: EW] = {1'b1, 5'd31};
    for (int b = CH - 1; b >= 0; b--) shift(img[b]);
    check("R6 chain image", 256'(m_pre), 256'(img));
    do_upd(); rand_inputs(); #1; check_outs("R6 serial map");

    // R5: wrong-mode strobes ignored
    load_par = 1;
    for (int t = 0; t < 10; t++) begin shift_en = 1; ser_in = 1'($urandom); tick(); end
    shift_en = 0;
    load_par = 0; wr_en = 1; wr_all = 1; wr_entry = '0; tick(); wr_en = 0; wr_all = 0;
    check("R5 ser_out after ignored strobes", 256'(ser_out), 256'(m_pre[CH-1]));
    do_upd(); #1; check_outs("R5 ignored strobes");

    // R8: reset keeps preload
    for (int k = 0; k < NO; k++) pwrite(k, EW'($urandom), 0, 0);
    rst_n = 0; m_act = '0; #1;
    check("R8 reset clears active", 256'(out_en), 256'(0));
    tick(); rst_n = 1; tick();
    do_upd(); rand_inputs(); #1; check_outs("R8 preload kept");

    // R7: daisy chain, push everything out again
    for (int b = 0; b < CH; b++) shift(1'($urandom));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule